// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block queues executed stores in program order between execution and the L1 data cache. The pipeline allocates an entry for each store and receives its slot index. It then fills in the address with its byte-enable mask and the store data, each through its own write port and possibly in different cycles. When a store retires, the pipeline marks it, and retired stores leave from the head of the queue through a write port to the cache with a valid/ready handshake. A flush drops every store that has not yet retired. Retired stores stay in the queue until they have been written.

An executing load presents its address, byte mask and sequence number, and gets an answer in the same cycle. The answer is one of three: take forwarded data, read the cache, or wait and retry. Age is set by sequence numbers. A store is older than the load when the wrapped difference `ld_seq - st_seq`, read as a signed `SW`-bit value, is greater than zero. A two-state drain machine controls the cache writes. In `DR_IDLE` no write is offered; the machine moves to `DR_BUSY` once the head entry is retired. In `DR_BUSY` the head write is offered. After an accepted write the machine stays in `DR_BUSY` if the next entry is already retired, and otherwise returns to `DR_IDLE`.

Top module: `sb_store_buffer`

## Requirements
- R1: After reset the queue is empty, `alloc_ready` is 1 and `wr_valid` is 0.
- R2: Allocations receive consecutive slot indices starting at 0. While `DEPTH` entries are held, `alloc_ready` is 0.
- R3: `ld_resp` encodes 0 = none (when `ld_valid` is low), 1 = read cache, 2 = forward, 3 = wait. A load that overlaps no older store, including any load when the queue is empty, gets 1.
- R4: If any older store in the queue still has an unknown address, the load gets 3, whatever else matches.
- R5: Among the older stores whose word address equals the load's and whose byte enables overlap the load's, the youngest decides the answer. If its data is known and its enables cover every byte of the load, the answer is 2, and `ld_data` carries that store's bytes in the load's byte lanes with zeros in all other lanes.
- R6: If that youngest overlapping store covers only some of the load's bytes, or its data is not yet known, the answer is 3.
- R7: Stores that are the same age as the load or younger have no effect on the answer.
- R8: Addresses are compared as word addresses (byte address bits above log2(DW/8)). Addresses in the same word whose byte enables do not overlap do not match.
- R9: Retired stores are written to the cache in queue order, one for each accepted handshake. `wr_valid` rises in the second cycle after the cycle in which `retire_valid` marks the head entry. While `wr_ready` is low, `wr_valid`, `wr_addr`, `wr_be` and `wr_data` hold their values.
- R10: A flush removes all unretired entries, so they no longer affect loads, and the next allocation reuses the slot after the last retired entry. Retired entries still forward and still drain. `alloc_ready` is 0 during a flush cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate an entry for a new store |
| alloc_seq | input | SW | Sequence number of the new store |
| alloc_ready | output | 1 | Allocation accepted this cycle |
| alloc_idx | output | log2(DEPTH) | Slot index given to the new store |
| addr_valid | input | 1 | Write an address to slot `addr_idx` |
| addr_idx | input | log2(DEPTH) | Slot that receives the address |
| addr_in | input | AW | Store byte address |
| addr_be | input | DW/8 | Store byte enables within the word |
| data_valid | input | 1 | Write data to slot `data_idx` |
| data_idx | input | log2(DEPTH) | Slot that receives the data |
| data_in | input | DW | Store data word |
| retire_valid | input | 1 | Retire the oldest unretired store |
| flush | input | 1 | Drop all unretired stores |
| ld_valid | input | 1 | Load lookup present |
| ld_addr | input | AW | Load byte address |
| ld_be | input | DW/8 | Load byte enables |
| ld_seq | input | SW | Load sequence number |
| ld_resp | output | 2 | Lookup answer (see R3) |
| ld_data | output | DW | Forwarded data, masked to the load bytes |
| wr_valid | output | 1 | Cache write offered |
| wr_addr | output | AW | Cache write word address (low bits zero) |
| wr_be | output | DW/8 | Cache write byte enables |
| wr_data | output | DW | Cache write data |
| wr_ready | input | 1 | Cache accepts the write |

## Verification
A wrong age bit or a stale valid bit shows up at once at `ld_resp`, because the lookup is combinational: a flushed store can still force a wait, or a retired store can fail to forward, in the same cycle as the load that checks it. Pointer damage shows at `alloc_idx` on the next allocation, and at `wr_addr` on the next handshake, as a write that is out of order or repeated. An error in the drain machine shows within two cycles of a retire, as `wr_valid` arriving late or dropping while `wr_ready` is low.

// File: rtl/sb_pkg.sv
package sb_pkg;

    typedef enum logic [1:0] {
        LD_NONE  = 2'd0,
        LD_CACHE = 2'd1,
        LD_FWD   = 2'd2,
        LD_WAIT  = 2'd3
    } ld_resp_e;

    typedef enum logic {
        DR_IDLE = 1'b0,
        DR_BUSY = 1'b1
    } dr_state_e;

endpackage

// File: rtl/sb_lookup.sv
module sb_lookup
    import sb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int PW    = 2,
    parameter int WW    = 30,
    parameter int BEW   = 4,
    parameter int DW    = 32,
    parameter int SW    = 8
) (
    input  logic [PW-1:0]    head,
    input  logic [DEPTH-1:0] ent_v,
    input  logic [DEPTH-1:0] ent_ak,
    input  logic [DEPTH-1:0] ent_dk,
    input  logic [WW-1:0]    ent_word [DEPTH],
    input  logic [BEW-1:0]   ent_be   [DEPTH],
    input  logic [DW-1:0]    ent_data [DEPTH],
    input  logic [SW-1:0]    ent_seq  [DEPTH],
    input  logic             ld_valid,
    input  logic [WW-1:0]    ld_word,
    input  logic [BEW-1:0]   ld_be,
    input  logic [SW-1:0]    ld_seq,
    output ld_resp_e         resp,
    output logic [DW-1:0]    data
);

    logic          unk;
    logic          hit;
    logic [PW-1:0] hidx;
    logic [PW-1:0] pos;
    logic [DW-1:0] lane_mask;

    function automatic logic is_older(input logic [SW-1:0] st_seq);
        logic [SW-1:0] diff;
        diff = ld_seq - st_seq;
        return (diff != '0) && !diff[SW-1];
    endfunction

    // scan oldest to youngest; the last hit is the youngest older match
    always_comb begin
        unk  = 1'b0;
        hit  = 1'b0;
        hidx = '0;
        pos  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            pos = head + PW'(i);
            if (ent_v[pos] && is_older(ent_seq[pos])) begin
                if (!ent_ak[pos]) begin
                    unk = 1'b1;
                end else if ((ent_word[pos] == ld_word) && |(ent_be[pos] & ld_be)) begin
                    hit  = 1'b1;
                    hidx = pos;
                end
            end
        end
    end

    always_comb begin
        for (int b = 0; b < BEW; b++) begin
            lane_mask[b*8 +: 8] = {8{ld_be[b]}};
        end
    end

    always_comb begin
        resp = LD_NONE;
        data = '0;
        if (ld_valid) begin
            if (unk) begin
                resp = LD_WAIT;
            end else if (hit) begin
                if (ent_dk[hidx] && ((ent_be[hidx] & ld_be) == ld_be)) begin
                    resp = LD_FWD;
                    data = ent_data[hidx] & lane_mask;
                end else begin
                    resp = LD_WAIT;
                end
            end else begin
                resp = LD_CACHE;
            end
        end
    end

endmodule

// File: rtl/sb_drain_fsm.sv
module sb_drain_fsm
    import sb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic head_rdy,
    input  logic next_rdy,
    input  logic wr_ready,
    output logic wr_valid,
    output logic pop
);

    dr_state_e state_q;
    dr_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DR_IDLE: if (head_rdy) state_d = DR_BUSY;
            DR_BUSY: if (wr_ready && !next_rdy) state_d = DR_IDLE;
            default: state_d = DR_IDLE;
        endcase
    end

    always_comb begin
        wr_valid = (state_q == DR_BUSY);
        pop      = (state_q == DR_BUSY) && wr_ready;
    end

    // R9: an offered write is held until accepted
    p_wr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> wr_valid);

    // R9: a write is offered only for a retired head entry
    p_busy_head_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> head_rdy);

endmodule

// File: rtl/sb_store_buffer.sv
module sb_store_buffer
    import sb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int SW    = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int BEW  = DW / 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           alloc_valid,
    input  logic [SW-1:0]  alloc_seq,
    output logic           alloc_ready,
    output logic [PW-1:0]  alloc_idx,
    input  logic           addr_valid,
    input  logic [PW-1:0]  addr_idx,
    input  logic [AW-1:0]  addr_in,
    input  logic [BEW-1:0] addr_be,
    input  logic           data_valid,
    input  logic [PW-1:0]  data_idx,
    input  logic [DW-1:0]  data_in,
    input  logic           retire_valid,
    input  logic           flush,
    input  logic           ld_valid,
    input  logic [AW-1:0]  ld_addr,
    input  logic [BEW-1:0] ld_be,
    input  logic [SW-1:0]  ld_seq,
    output logic [1:0]     ld_resp,
    output logic [DW-1:0]  ld_data,
    output logic           wr_valid,
    output logic [AW-1:0]  wr_addr,
    output logic [BEW-1:0] wr_be,
    output logic [DW-1:0]  wr_data,
    input  logic           wr_ready
);

    localparam int OFF = $clog2(BEW);
    localparam int WW  = AW - OFF;

    logic [PW:0]        head_q, tail_q, rp_q;
    logic [PW:0]        count;
    logic [DEPTH-1:0]   v_q, ak_q, dk_q, rt_q;
    logic [WW-1:0]      word_q [DEPTH];
    logic [BEW-1:0]     be_q   [DEPTH];
    logic [DW-1:0]      data_q [DEPTH];
    logic [SW-1:0]      seq_q  [DEPTH];
    logic [PW-1:0]      hidx, nidx, ridx;
    logic               alloc_fire, ret_ok, pop;
    logic               head_rdy, next_rdy;
    ld_resp_e           resp;

    assign count       = tail_q - head_q;
    assign hidx        = head_q[PW-1:0];
    assign nidx        = hidx + 1'b1;
    assign ridx        = rp_q[PW-1:0];
    assign alloc_ready = (count != (PW+1)'(DEPTH)) && !flush;
    assign alloc_idx   = tail_q[PW-1:0];
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign ret_ok      = retire_valid && (rp_q != tail_q);
    assign head_rdy    = v_q[hidx] && rt_q[hidx];
    assign next_rdy    = v_q[nidx] && rt_q[nidx];

    // control state: pointers and per-entry flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            rp_q   <= '0;
            v_q    <= '0;
            ak_q   <= '0;
            dk_q   <= '0;
            rt_q   <= '0;
        end else begin
            if (pop) begin
                v_q[hidx]  <= 1'b0;
                rt_q[hidx] <= 1'b0;
                head_q     <= head_q + 1'b1;
            end
            if (ret_ok) begin
                rt_q[ridx] <= 1'b1;
                rp_q       <= rp_q + 1'b1;
            end
            if (addr_valid) ak_q[addr_idx] <= 1'b1;
            if (data_valid) dk_q[data_idx] <= 1'b1;
            if (alloc_fire) begin
                v_q[alloc_idx]  <= 1'b1;
                ak_q[alloc_idx] <= 1'b0;
                dk_q[alloc_idx] <= 1'b0;
                rt_q[alloc_idx] <= 1'b0;
                tail_q          <= tail_q + 1'b1;
            end
            if (flush) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (!(rt_q[i] || (ret_ok && (PW'(i) == ridx)))) begin
                        v_q[i] <= 1'b0;
                    end
                end
                tail_q <= rp_q + (PW+1)'(ret_ok);
            end
        end
    end

    // payload, no reset needed
    always_ff @(posedge clk) begin
        if (addr_valid) begin
            word_q[addr_idx] <= addr_in[AW-1:OFF];
            be_q[addr_idx]   <= addr_be;
        end
        if (data_valid) data_q[data_idx] <= data_in;
        if (alloc_fire) seq_q[alloc_idx] <= alloc_seq;
    end

    sb_lookup #(
        .DEPTH(DEPTH), .PW(PW), .WW(WW), .BEW(BEW), .DW(DW), .SW(SW)
    ) i_lookup (
        .head     (hidx),
        .ent_v    (v_q),
        .ent_ak   (ak_q),
        .ent_dk   (dk_q),
        .ent_word (word_q),
        .ent_be   (be_q),
        .ent_data (data_q),
        .ent_seq  (seq_q),
        .ld_valid (ld_valid),
        .ld_word  (ld_addr[AW-1:OFF]),
        .ld_be    (ld_be),
        .ld_seq   (ld_seq),
        .resp     (resp),
        .data     (ld_data)
    );

    assign ld_resp = resp;

    sb_drain_fsm i_drain (
        .clk      (clk),
        .rst_n    (rst_n),
        .head_rdy (head_rdy),
        .next_rdy (next_rdy),
        .wr_ready (wr_ready),
        .wr_valid (wr_valid),
        .pop      (pop)
    );

    assign wr_addr = {word_q[hidx], {OFF{1'b0}}};
    assign wr_be   = be_q[hidx];
    assign wr_data = data_q[hidx];

    // R2: occupancy never exceeds the depth
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= (PW+1)'(DEPTH));

    // R2: an accepted allocation without a drain grows the queue by one
    p_alloc_grow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_ready && !pop) |=> (count == $past(count) + 1'b1));

    // R3: an empty queue always sends the load to the cache
    p_empty_cache_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && (count == '0)) |-> (ld_resp == LD_CACHE));

    // R9: the offered write is stable while stalled
    p_wr_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> ($stable(wr_addr) && $stable(wr_data) && $stable(wr_be)));

    // R10: after a flush no unretired entry remains
    p_flush_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (tail_q == rp_q));

endmodule

// File: tb/test_sb_store_buffer.sv
`timescale 1ns/1ps
module test_sb_store_buffer;

    localparam int DEPTH = 4;
    localparam int AW    = 32;
    localparam int DW    = 32;
    localparam int SW    = 8;
    localparam int PW    = 2;
    localparam int BEW   = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           alloc_valid = 1'b0;
    logic [SW-1:0]  alloc_seq = '0;
    logic           alloc_ready;
    logic [PW-1:0]  alloc_idx;
    logic           addr_valid = 1'b0;
    logic [PW-1:0]  addr_idx = '0;
    logic [AW-1:0]  addr_in = '0;
    logic [BEW-1:0] addr_be = '0;
    logic           data_valid = 1'b0;
    logic [PW-1:0]  data_idx = '0;
    logic [DW-1:0]  data_in = '0;
    logic           retire_valid = 1'b0;
    logic           flush = 1'b0;
    logic           ld_valid = 1'b0;
    logic [AW-1:0]  ld_addr = '0;
    logic [BEW-1:0] ld_be = '0;
    logic [SW-1:0]  ld_seq = '0;
    logic [1:0]     ld_resp;
    logic [DW-1:0]  ld_data;
    logic           wr_valid;
    logic [AW-1:0]  wr_addr;
    logic [BEW-1:0] wr_be;
    logic [DW-1:0]  wr_data;
    logic           wr_ready = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sb_store_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .SW(SW)) i_sb_store_buffer (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_seq(alloc_seq),
        .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .addr_valid(addr_valid), .addr_idx(addr_idx), .addr_in(addr_in), .addr_be(addr_be),
        .data_valid(data_valid), .data_idx(data_idx), .data_in(data_in),
        .retire_valid(retire_valid), .flush(flush),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_be(ld_be), .ld_seq(ld_seq),
        .ld_resp(ld_resp), .ld_data(ld_data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data),
        .wr_ready(wr_ready)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_alloc(input logic [SW-1:0] seq, input logic [PW-1:0] exp_idx, input string req);
        alloc_valid = 1'b1;
        alloc_seq   = seq;
        #0.5;
        chk(req, {63'd0, alloc_ready}, 64'd1);
        chk(req, {62'd0, alloc_idx}, {62'd0, exp_idx});
        step();
        alloc_valid = 1'b0;
    endtask

    task automatic set_addr(input logic [PW-1:0] idx, input logic [AW-1:0] a, input logic [BEW-1:0] be);
        addr_valid = 1'b1; addr_idx = idx; addr_in = a; addr_be = be;
        step();
        addr_valid = 1'b0;
    endtask

    task automatic set_data(input logic [PW-1:0] idx, input logic [DW-1:0] d);
        data_valid = 1'b1; data_idx = idx; data_in = d;
        step();
        data_valid = 1'b0;
    endtask

    task automatic look(input logic [AW-1:0] a, input logic [BEW-1:0] be, input logic [SW-1:0] seq,
                        input logic [1:0] exp_resp, input logic [DW-1:0] exp_data, input string req);
        ld_valid = 1'b1; ld_addr = a; ld_be = be; ld_seq = seq;
        #1;
        chk(req, {62'd0, ld_resp}, {62'd0, exp_resp});
        if (exp_resp == 2'd2) chk(req, {32'd0, ld_data}, {32'd0, exp_data});
        ld_valid = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        chk("R1 alloc_ready", {63'd0, alloc_ready}, 64'd1);
        chk("R1 wr_valid", {63'd0, wr_valid}, 64'd0);
        look(32'h100, 4'hF, 8'd5, 2'd1, '0, "R3 empty to cache");
        #1;
        chk("R3 idle none", {62'd0, ld_resp}, 64'd0);
    endtask

    task automatic t_forward();
        do_alloc(8'd10, 2'd0, "R2 idx0");
        set_addr(2'd0, 32'h100, 4'hF);
        set_data(2'd0, 32'hAABBCCDD);
        look(32'h100, 4'hF, 8'd11, 2'd2, 32'hAABBCCDD, "R5 forward");
        look(32'h102, 4'b1100, 8'd11, 2'd2, 32'hAABB0000, "R8 word match masked");
        look(32'h100, 4'hF, 8'd9, 2'd1, '0, "R7 younger store ignored");
        look(32'h100, 4'hF, 8'd10, 2'd1, '0, "R7 same age ignored");
        look(32'h200, 4'hF, 8'd11, 2'd1, '0, "R3 no match");
    endtask

    task automatic t_youngest();
        do_alloc(8'd12, 2'd1, "R2 idx1");
        set_addr(2'd1, 32'h101, 4'b0011);
        set_data(2'd1, 32'h11112222);
        look(32'h100, 4'b0011, 8'd13, 2'd2, 32'h00002222, "R5 youngest forwards");
        look(32'h100, 4'hF, 8'd13, 2'd3, '0, "R6 partial cover waits");
        look(32'h100, 4'b1100, 8'd13, 2'd2, 32'hAABB0000, "R8 no byte overlap skips");
    endtask

    task automatic t_unknown();
        do_alloc(8'd14, 2'd2, "R2 idx2");
        look(32'h300, 4'hF, 8'd15, 2'd3, '0, "R4 unknown address waits");
        look(32'h100, 4'b0011, 8'd15, 2'd3, '0, "R4 wait beats forward");
        look(32'h300, 4'hF, 8'd13, 2'd1, '0, "R7 younger unknown ignored");
        set_addr(2'd2, 32'h300, 4'hF);
        look(32'h300, 4'hF, 8'd15, 2'd3, '0, "R6 data unknown waits");
        set_data(2'd2, 32'h55667788);
        look(32'h300, 4'hF, 8'd15, 2'd2, 32'h55667788, "R5 forward after data");
    endtask

    task automatic t_full();
        do_alloc(8'd16, 2'd3, "R2 idx3");
        #1;
        chk("R2 full stalls", {63'd0, alloc_ready}, 64'd0);
    endtask

    task automatic t_drain_flush();
        retire_valid = 1'b1;
        step();
        retire_valid = 1'b0;
        chk("R9 no write yet", {63'd0, wr_valid}, 64'd0);
        step();
        chk("R9 write offered", {63'd0, wr_valid}, 64'd1);
        chk("R9 addr", {32'd0, wr_addr}, 64'h100);
        chk("R9 be", {60'd0, wr_be}, 64'hF);
        chk("R9 data", {32'd0, wr_data}, 64'hAABBCCDD);
        retire_valid = 1'b1;
        step();
        retire_valid = 1'b0;
        chk("R9 hold valid", {63'd0, wr_valid}, 64'd1);
        chk("R9 hold data", {32'd0, wr_data}, 64'hAABBCCDD);
        flush = 1'b1;
        #1;
        chk("R10 alloc blocked in flush", {63'd0, alloc_ready}, 64'd0);
        step();
        flush = 1'b0;
        look(32'h300, 4'hF, 8'd17, 2'd1, '0, "R10 flushed store gone");
        look(32'h400, 4'hF, 8'd17, 2'd1, '0, "R10 flushed unknown gone");
        look(32'h100, 4'hF, 8'd17, 2'd3, '0, "R10 retired partial kept");
        look(32'h100, 4'b1100, 8'd17, 2'd2, 32'hAABB0000, "R10 retired forwards");
        wr_ready = 1'b1;
        step();
        chk("R9 second write", {63'd0, wr_valid}, 64'd1);
        chk("R9 second be", {60'd0, wr_be}, 64'h3);
        chk("R9 second data", {32'd0, wr_data}, 64'h11112222);
        step();
        chk("R9 drained", {63'd0, wr_valid}, 64'd0);
        wr_ready = 1'b0;
        look(32'h100, 4'hF, 8'd30, 2'd1, '0, "R3 drained to cache");
        do_alloc(8'd20, 2'd2, "R10 reuse slot");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_forward();
        t_youngest();
        t_unknown();
        t_full();
        t_drain_flush();
        step();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule